// File: doc/BRIEF.md
# Chip-Select Capable Output Bank

This block owns a small bank of output pins, eight by default, each of which can act as a plain general-purpose output or as a chip select for a serial peripheral controller. Every pin has a one-bit output latch. Software changes the latches through a strobe register with a set half and a clear half, so single pins can be raised or dropped without a read-modify-write. A configuration register chooses, for each pin, whether it is in chip-select mode and whether its output is inverted.

A pin drives its latch value exclusive-ORed with its invert bit. A pin in chip-select mode does the same while the transfer-active input is high. While that input is low, the pin is held at its inactive level, which is the value a set latch would give. Clearing the latch therefore asserts an active-low select, and setting the invert bit makes the select active-high. At the system level pin n serves chip-select number base + n, where the base defaults to 1. The latch values are also brought out as a status vector.

Top module: `csgpo_bank`

## Requirements
- R1: After reset the configuration register is zero, every latch is 1, `latch_status` reads all ones and every pin drives 1.
- R2: A strobe write (`wr_sel`=1) whose bit [N+i] is 1 and bit [i] is 0 sets latch i.
- R3: A strobe write whose bit [i] is 1 and bit [N+i] is 0 clears latch i.
- R4: Strobe bits that are zero, and any configuration write, leave the latches unchanged. A strobe write leaves the configuration unchanged.
- R5: A strobe write with both bit [N+i] and bit [i] set leaves latch i unchanged.
- R6: The strobe value 0xFF00 sets all eight latches, which deasserts every active-low chip select.
- R7: A configuration write (`wr_sel`=0) stores bits [N+i] as the chip-select mode of pin i and bits [i] as its invert bit. A pin that is not in chip-select mode drives latch XOR invert.
- R8: A chip-select-mode pin drives 1 XOR invert while `xfer_active` is low, whatever its latch holds.
- R9: A chip-select-mode pin drives latch XOR invert while `xfer_active` is high, so an inverted pin gives an active-high select.
- R10: Every write and every change of `xfer_active` reaches `pin_out` and `latch_status` at the first rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects configuration, 1 selects the set/clear strobe |
| wr_data | input | 2*NPINS | Write data: upper half is mode or set, lower half is invert or clear |
| xfer_active | input | 1 | High while a serial transfer is in progress |
| pin_out | output | NPINS | Registered pin levels |
| latch_status | output | NPINS | Current latch values |

## Verification
A corrupted latch appears on `latch_status` at the next edge, and on any pin that is not in chip-select mode or is selected during a transfer. A latch that drops a set or clear shows up one cycle after the strobe. A wrong mode or invert bit appears at the pins one cycle after the configuration write. It may stay hidden on a chip-select pin until `xfer_active` goes high, so the random mix toggles that input on most cycles. Pairs of set and clear bits on the same pin are generated on purpose, so that a priority error shows up as a latch that moves when it should hold.

// File: rtl/csgpo_pkg.sv
package csgpo_pkg;
  typedef enum logic {
    SEL_CFG    = 1'b0,
    SEL_STROBE = 1'b1
  } csgpo_sel_e;
endpackage

// File: rtl/csgpo_cfg_reg.sv
module csgpo_cfg_reg #(
  parameter int NPINS = 8,
  localparam int W = 2 * NPINS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_d,
  output logic [W-1:0] cfg_q
);
  always_comb cfg_d = we ? wdata : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/csgpo_latch_cell.sv
module csgpo_latch_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic lat_d,
  output logic lat_q
);
  // simultaneous set and clear holds the latch
  always_comb begin
    unique case ({set_i, clr_i})
      2'b10:   lat_d = 1'b1;
      2'b01:   lat_d = 1'b0;
      default: lat_d = lat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= 1'b1;
    else     lat_q <= lat_d;
  end
endmodule

// File: rtl/csgpo_pin_drive.sv
module csgpo_pin_drive #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lat_d,
  input  logic [NPINS-1:0] cs_mode,
  input  logic [NPINS-1:0] invert,
  input  logic             xfer_active,
  output logic [NPINS-1:0] pin_q
);
  logic [NPINS-1:0] level;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      if (cs_mode[i] && !xfer_active) level[i] = 1'b1 ^ invert[i];
      else                            level[i] = lat_d[i] ^ invert[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '1;
    else     pin_q <= level;
  end
endmodule

// File: rtl/csgpo_bank.sv
module csgpo_bank #(
  parameter int NPINS = 8,
  localparam int W = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             xfer_active,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] latch_status
);
  import csgpo_pkg::*;

  logic             cfg_we;
  logic             stb_we;
  logic [W-1:0]     cfg_d;
  logic [W-1:0]     cfg_q;
  logic [NPINS-1:0] set_v;
  logic [NPINS-1:0] clr_v;
  logic [NPINS-1:0] lat_d;
  logic [NPINS-1:0] lat_q;

  always_comb begin
    cfg_we = wr_en && (csgpo_sel_e'(wr_sel) == SEL_CFG);
    stb_we = wr_en && (csgpo_sel_e'(wr_sel) == SEL_STROBE);
    set_v  = stb_we ? wr_data[W-1:NPINS] : '0;
    clr_v  = stb_we ? wr_data[NPINS-1:0] : '0;
  end

  csgpo_cfg_reg #(.NPINS(NPINS)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (wr_data),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_lat
    csgpo_latch_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .lat_d (lat_d[i]),
      .lat_q (lat_q[i])
    );
  end

  csgpo_pin_drive #(.NPINS(NPINS)) u_drive (
    .clk         (clk),
    .rst         (rst),
    .lat_d       (lat_d),
    .cs_mode     (cfg_d[W-1:NPINS]),
    .invert      (cfg_d[NPINS-1:0]),
    .xfer_active (xfer_active),
    .pin_q       (pin_out)
  );

  assign latch_status = lat_q;
endmodule

// File: rtl/csgpo_bank_chk.sv
module csgpo_bank_chk #(
  parameter int NPINS = 8,
  localparam int W = 2 * NPINS
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [W-1:0]     wr_data,
  input logic             xfer_active,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] latch_status,
  input logic [W-1:0]     cfg_q
);
  logic stb;
  logic [NPINS-1:0] hi, lo;
  assign stb = wr_en && wr_sel;
  assign hi  = wr_data[W-1:NPINS];
  assign lo  = wr_data[NPINS-1:0];

  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    stb |=> ((latch_status & $past(hi & ~lo)) == $past(hi & ~lo))); // R2
  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (rst)
    stb |=> ((latch_status & $past(lo & ~hi)) == '0)); // R3
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(latch_status)); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    stb |=> (((latch_status ^ $past(latch_status)) & $past(hi & lo)) == '0)); // R5
  AST_STROBE_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    stb |=> $stable(cfg_q)); // R4
  AST_PLAIN_PIN: assert property (@(posedge clk) disable iff (rst)
    ((pin_out ^ latch_status ^ cfg_q[NPINS-1:0]) & ~cfg_q[W-1:NPINS]) == '0); // R7
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !xfer_active |=> (((pin_out ^ ~cfg_q[NPINS-1:0]) & cfg_q[W-1:NPINS]) == '0)); // R8
  AST_CS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    xfer_active |=> (((pin_out ^ latch_status ^ cfg_q[NPINS-1:0]) & cfg_q[W-1:NPINS]) == '0)); // R9
endmodule

bind csgpo_bank csgpo_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .xfer_active  (xfer_active),
  .pin_out      (pin_out),
  .latch_status (latch_status),
  .cfg_q        (cfg_q)
);

// File: tb/csgpo_bank_bench.sv
module csgpo_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic xfer_active = 1'b0;
  logic [N-1:0] pin_out;
  logic [N-1:0] latch_status;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] m_lat;
  logic [W-1:0] m_cfg;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csgpo_bank #(.NPINS(N)) u_csgpo_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_active(xfer_active), .pin_out(pin_out), .latch_status(latch_status)
  );

  function automatic logic [N-1:0] next_lat(logic [N-1:0] l, logic [W-1:0] d);
    logic [N-1:0] h = d[W-1:N];
    logic [N-1:0] c = d[N-1:0];
    return (l | (h & ~c)) & ~(c & ~h);
  endfunction

  function automatic logic [N-1:0] exp_pins(logic [N-1:0] l, logic [W-1:0] c, logic xa);
    logic [N-1:0] cs = c[W-1:N];
    return (l | (cs & {N{~xa}})) ^ c[N-1:0];
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at following negedge
  task automatic step(logic en, logic sel, logic [W-1:0] d, logic xa, string req);
    wr_en = en; wr_sel = sel; wr_data = d; xfer_active = xa;
    @(posedge clk);
    @(negedge clk);
    if (en && sel) m_lat = next_lat(m_lat, d);
    if (en && !sel) m_cfg = d;
    wr_en = 1'b0;
    check({req, " status"}, latch_status, m_lat);
    check({req, " pins"}, pin_out, exp_pins(m_lat, m_cfg, xa));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C1A));
    m_lat = '1; m_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 status", latch_status, '1);
    check("R1 pins", pin_out, '1);
    // R3 clear pins 0 and 5
    step(1, 1, 16'h0021, 0, "R3");
    check("R3 direct", latch_status, 8'hDE);
    // R2 set pin 5
    step(1, 1, 16'h2000, 0, "R2");
    check("R2 direct", latch_status, 8'hFE);
    // R5 both on pin 0 and 1: hold
    step(1, 1, 16'h0303, 0, "R5");
    check("R5 direct", latch_status, 8'hFE);
    // R4 zero strobe bits and non-write
    step(1, 1, 16'h0000, 0, "R4");
    step(0, 1, 16'hFFFF, 0, "R4 idle");
    check("R4 direct", latch_status, 8'hFE);
    // R7 invert on plain pins, R4 config write keeps latches
    step(1, 0, 16'h00F0, 0, "R7");
    check("R7 direct", pin_out, 8'h0E);
    check("R4 cfg", latch_status, 8'hFE);
    // R8 CS mode on pins 0..3, idle -> inactive
    step(1, 0, 16'h0F01, 0, "R8");
    check("R8 direct", pin_out[3:0], 4'h0 ^ 4'hE ^ 4'h0 | 4'hE);
    // R9 transfer active: pin0 latch 0 inverted -> 1
    step(0, 0, 16'h0, 1, "R9");
    check("R9 direct", pin_out[0], 1'b1);
    // R10 xfer drop reaches pins next edge
    step(0, 0, 16'h0, 0, "R10");
    check("R10 direct", pin_out[0], 1'b0);
    // R6 all set
    step(1, 1, 16'h00FF, 1, "R6 prep");
    step(1, 1, 16'hFF00, 1, "R6");
    check("R6 direct", latch_status, 8'hFF);
    step(1, 0, 16'h0000, 0, "R6 cfg");
    check("R6 pins", pin_out, 8'hFF);
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] d = W'($urandom);
      logic s = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) d[W-1:N] = d[N-1:0];
      step(($urandom % 3) != 0, s, d, 1'($urandom), "R7 R8 R9 R10 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule